// File: doc/BRIEF.md
# Dual-Clock FIFO Bank with Programmable Level Flags

This block is one 9-bit FIFO bank. It has a write side and a read side, and each side runs on its own clock. The two clocks may be one net or may be unrelated. A write needs both write enables high on a write-clock edge. A read needs both read enables high on a read-clock edge. The pointers cross between the clock domains as Gray code through two-flop synchronisers. Full and almost-full are derived in the write domain. Empty and almost-empty are derived in the read domain.

The two threshold offsets are loaded through a strobe and a value input on the write clock. A small two-state sequencer steers each strobe to an offset:
- State `LD_EMPTY_OFS`: a strobe writes the almost-empty offset, and the transition *ae_loaded* moves to `LD_FULL_OFS`.
- State `LD_FULL_OFS`: a strobe writes the almost-full offset, and the transition *af_loaded* returns to `LD_EMPTY_OFS`.
- With no strobe, either state holds.
- Reset puts the sequencer in `LD_EMPTY_OFS` and sets both offsets to 7.

The read data bus is gated by an output enable. When the enable is low, the bus reads as zero and a valid line goes low. This stands in for a three-state bus.

Top module: `dcfifo_bank`

## Requirements
- R1: A word on `din` is stored on a rising `wclk` edge only when `wen1` and `wen2` are both 1 and `full` is 0. Words leave in the order they were stored.
- R2: A read occurs on a rising `rclk` edge only when `ren1` and `ren2` are both 1 and `empty` is 0. The word read appears on the internal output register just after that edge.
- R3: A write attempted while `full` is 1 is dropped. Stored contents and order are unchanged.
- R4: A read attempted while `empty` is 1 is dropped. The output register holds its previous value.
- R5: After reset, `empty`=1, `full`=0, `almost_empty`=1, `almost_full`=0, and the output register is zero.
- R6: Once both clock domains have settled, `empty` is 1 exactly when 0 words are held. `full` is 1 exactly when DEPTH words are held.
- R7: Once settled, `almost_empty` is 1 exactly when the number of words held is at most the almost-empty offset. The offset defaults to 7.
- R8: Once settled, `almost_full` is 1 exactly when the number of free locations (DEPTH minus words held) is at most the almost-full offset. The offset defaults to 7.
- R9: The first `ld_stb` after reset loads `ld_val` into the almost-empty offset. The next strobe loads the almost-full offset, and later strobes keep alternating. Reset returns both offsets to 7 and returns the sequencer to almost-empty first.
- R10: With `oe`=0, `dout` is all zero and `dout_vld` is 0. With `oe`=1, `dout` shows the output register and `dout_vld` is 1.
- R11: The Gray-coded write and read pointers each change by at most one bit per clock of their own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wen1 | input | 1 | Write enable, first of the pair |
| wen2 | input | 1 | Write enable, second of the pair |
| din | input | 9 | Write data |
| ld_stb | input | 1 | Offset load strobe (write clock) |
| ld_val | input | log2(DEPTH) | Offset value to load |
| ren1 | input | 1 | Read enable, first of the pair |
| ren2 | input | 1 | Read enable, second of the pair |
| oe | input | 1 | Output enable for the read data |
| dout | output | 9 | Gated read data |
| dout_vld | output | 1 | High while read data is driven |
| empty | output | 1 | No words held (read domain) |
| full | output | 1 | No free locations (write domain) |
| almost_empty | output | 1 | Words held at or below the empty offset |
| almost_full | output | 1 | Free locations at or below the full offset |

## Verification
The write and read clocks run at unrelated periods. The FIFO is driven through these patterns:
- Single-enable writes. These separate gating on both enables from gating on either one.
- A fill to exactly DEPTH, followed by extra writes. This shows whether full blocks pointer movement.
- Reads past empty. These show whether the output register holds its value.
- Fill levels just on and just past each threshold, first with the default offsets, then with loaded offsets, then after a reset. These pin down comparison off-by-ones and the order in which strobes load the two offsets.
- A long streaming run with gapped writes and slower reads. This keeps the pointers crossing the domains constantly, and the scoreboard then exposes reordering or lost words.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    localparam int DATA_W  = 9;
    localparam int DEF_OFS = 7;

    typedef enum logic {
        LD_EMPTY_OFS = 1'b0,
        LD_FULL_OFS  = 1'b1
    } ld_state_t;

endpackage

// File: rtl/dcfifo_sync2.sv
module dcfifo_sync2 #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcfifo_ofs_load.sv
module dcfifo_ofs_load
    import dcfifo_pkg::*;
#(
    parameter int OW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_stb,
    input  logic [OW-1:0] ld_val,
    output logic [OW-1:0] ae_ofs,
    output logic [OW-1:0] af_ofs
);
    ld_state_t st, st_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LD_EMPTY_OFS;
        else        st <= st_nx;
    end

    // transitions: ae_loaded, af_loaded
    always_comb begin
        st_nx = st;
        unique case (st)
            LD_EMPTY_OFS: if (ld_stb) st_nx = LD_FULL_OFS;
            LD_FULL_OFS:  if (ld_stb) st_nx = LD_EMPTY_OFS;
            default:      st_nx = LD_EMPTY_OFS;
        endcase
    end

    // outputs: offset registers written by the state that owns them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_ofs <= OW'(DEF_OFS);
            af_ofs <= OW'(DEF_OFS);
        end else if (ld_stb) begin
            unique case (st)
                LD_EMPTY_OFS: ae_ofs <= ld_val;
                LD_FULL_OFS:  af_ofs <= ld_val;
                default:      ae_ofs <= ld_val;
            endcase
        end
    end

    p_ae_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && st == LD_EMPTY_OFS) |=> (ae_ofs == $past(ld_val) && $stable(af_ofs)));

    p_af_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && st == LD_FULL_OFS) |=> (af_ofs == $past(ld_val) && $stable(ae_ofs)));
endmodule

// File: rtl/dcfifo_bank.sv
module dcfifo_bank
    import dcfifo_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wen1,
    input  logic              wen2,
    input  logic [DATA_W-1:0] din,
    input  logic              ld_stb,
    input  logic [AW-1:0]     ld_val,
    input  logic              ren1,
    input  logic              ren2,
    input  logic              oe,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              empty,
    output logic              full,
    output logic              almost_empty,
    output logic              almost_full
);
    function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wbin, wgray, rbin, rgray;
    logic [PW-1:0]     rgray_w, wgray_r;
    logic [PW-1:0]     wcnt, rcnt;
    logic [PW:0]       wfree;
    logic [AW-1:0]     ae_ofs, af_ofs;
    logic [DATA_W-1:0] q_r;
    logic              wr_go, rd_go;

    dcfifo_ofs_load #(.OW(AW)) u_ofs (
        .clk(wclk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_val(ld_val),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    dcfifo_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w));
    dcfifo_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

    // ---------------- write domain ----------------
    assign wr_go = wen1 & wen2 & ~full;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_go) begin
            wbin  <= wbin + 1'b1;
            wgray <= b2g(wbin + 1'b1);
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_go) mem[wbin[AW-1:0]] <= din;
    end

    assign full        = (wgray == {~rgray_w[PW-1 -: 2], rgray_w[PW-3:0]});
    assign wcnt        = wbin - g2b(rgray_w);
    assign wfree       = (PW+1)'(DEPTH) - {1'b0, wcnt};
    assign almost_full = (wfree <= (PW+1)'(af_ofs));

    // ---------------- read domain ----------------
    assign rd_go = ren1 & ren2 & ~empty;

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            q_r   <= '0;
        end else if (rd_go) begin
            rbin  <= rbin + 1'b1;
            rgray <= b2g(rbin + 1'b1);
            q_r   <= mem[rbin[AW-1:0]];
        end
    end

    assign empty        = (rgray == wgray_r);
    assign rcnt         = g2b(wgray_r) - rbin;
    assign almost_empty = (rcnt <= PW'(ae_ofs));

    assign dout     = oe ? q_r : '0;
    assign dout_vld = oe;

    // ---------------- assertions ----------------
    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
        (full && wen1 && wen2) |=> $stable(wbin));

    p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rst_n)
        (empty && ren1 && ren2) |=> ($stable(rbin) && $stable(q_r)));

    p_wgray_step_r11: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    p_rgray_step_r11: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: tb/sim_dcfifo_bank.sv
`timescale 1ns/1ps
module sim_dcfifo_bank;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    logic wclk = 0, rclk = 0, rst_n = 0;
    logic wen1 = 0, wen2 = 0, ren1 = 0, ren2 = 0, oe = 1, ld_stb = 0;
    logic [8:0] din = '0;
    logic [AW-1:0] ld_val = '0;
    logic [8:0] dout;
    logic dout_vld, empty, full, almost_empty, almost_full;

    dcfifo_bank #(.DEPTH(DEPTH)) u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1(wen1), .wen2(wen2),
        .din(din), .ld_stb(ld_stb), .ld_val(ld_val), .ren1(ren1), .ren2(ren2),
        .oe(oe), .dout(dout), .dout_vld(dout_vld), .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    always #10 wclk = ~wclk;   // 50 MHz
    always #11 rclk = ~rclk;

    int n_chk = 0, n_bad = 0;
    int ae_o = 7, af_o = 7;
    logic [8:0] sb[$];
    logic [8:0] last_rd = '0;
    logic [8:0] seq = '0;
    bit wdone;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: pushes expected words
    task automatic wr(input logic [8:0] d, input bit e1 = 1, input bit e2 = 1);
        @(negedge wclk);
        din = d; wen1 = e1; wen2 = e2;
        if (e1 && e2 && !full) sb.push_back(d);
        @(posedge wclk);
        #1 wen1 = 0; wen2 = 0;
    endtask

    task automatic wr_next();
        wr(seq);
        seq = seq + 9'd37;
    endtask

    // monitor: pops and compares
    task automatic rd();
        bit acc;
        logic [8:0] e;
        @(negedge rclk);
        ren1 = 1; ren2 = 1;
        acc = !empty;
        @(posedge rclk);
        #1 ren1 = 0; ren2 = 0;
        @(negedge rclk);
        if (acc) begin
            if (sb.size() == 0) check(0, "R4 read accepted with no data", 1, 0);
            else begin
                e = sb.pop_front();
                check(dout == e, "R1/R2 read order", dout, e);
                last_rd = e;
            end
        end else begin
            check(dout == last_rd, "R4 dout held on refused read", dout, last_rd);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge wclk);
        repeat (6) @(posedge rclk);
        @(negedge rclk);
    endtask

    task automatic chk_flags(input string tag);
        int sz;
        sz = sb.size();
        check(empty == (sz == 0), {"R6 empty ", tag}, empty, sz == 0);
        check(full == (sz == DEPTH), {"R6 full ", tag}, full, sz == DEPTH);
        check(almost_empty == (sz <= ae_o), {"R7 almost_empty ", tag}, almost_empty, sz <= ae_o);
        check(almost_full == ((DEPTH - sz) <= af_o), {"R8 almost_full ", tag}, almost_full,
              (DEPTH - sz) <= af_o);
    endtask

    task automatic load(input int v);
        @(negedge wclk);
        ld_stb = 1; ld_val = AW'(v);
        @(posedge wclk);
        #1 ld_stb = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; wen1 = 0; wen2 = 0; ren1 = 0; ren2 = 0; ld_stb = 0;
        repeat (3) @(posedge wclk);
        sb.delete(); last_rd = '0; ae_o = 7; af_o = 7;
        @(negedge wclk) rst_n = 1;
        settle();
    endtask

    task automatic fill_to(input int n);
        while (sb.size() < n) wr_next();
    endtask

    task automatic drain_to(input int n);
        while (sb.size() > n) rd();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        do_reset();
        // R5 reset state
        check(empty == 1, "R5 empty after reset", empty, 1);
        check(full == 0, "R5 full after reset", full, 0);
        check(almost_empty == 1, "R5 almost_empty after reset", almost_empty, 1);
        check(almost_full == 0, "R5 almost_full after reset", almost_full, 0);
        check(dout == 0, "R5 output register after reset", dout, 0);

        // R1 single enables must not write
        wr(9'h1AA, 1, 0);
        wr(9'h155, 0, 1);
        settle();
        check(empty == 1, "R1 single enable ignored", empty, 1);

        // R7 default threshold 7 / 8
        fill_to(7); settle(); chk_flags("7 words default");
        fill_to(8); settle(); chk_flags("8 words default");
        drain_to(0); settle(); chk_flags("drained");
        rd(); rd();   // R4 reads while empty

        // R8 / R6 / R3 near full
        fill_to(DEPTH - 8); settle(); chk_flags("free 8");
        fill_to(DEPTH - 7); settle(); chk_flags("free 7");
        fill_to(DEPTH);     settle(); chk_flags("full");
        wr(9'h0F0); wr(9'h00F); wr(9'h1FF);   // R3 writes while full
        settle(); chk_flags("R3 after writes on full");
        drain_to(0); settle(); chk_flags("drained after full");

        // R10 output enable gate
        oe = 0; #1;
        check(dout == 0, "R10 dout zero when oe low", dout, 0);
        check(dout_vld == 0, "R10 valid low when oe low", dout_vld, 0);
        oe = 1; #1;
        check(dout == last_rd, "R10 dout shown when oe high", dout, last_rd);
        check(dout_vld == 1, "R10 valid high when oe high", dout_vld, 1);

        // R9 load order: first strobe almost-empty, second almost-full
        load(20); load(30); ae_o = 20; af_o = 30;
        fill_to(20); settle(); chk_flags("R9 ae=20 at 20");
        fill_to(21); settle(); chk_flags("R9 ae=20 at 21");
        fill_to(DEPTH - 31); settle(); chk_flags("R9 af=30 free 31");
        fill_to(DEPTH - 30); settle(); chk_flags("R9 af=30 free 30");
        drain_to(0); settle();

        // R9 reset restores defaults and load order
        fill_to(5);
        do_reset();
        chk_flags("R9 after reset");
        fill_to(7); settle(); chk_flags("R9 default ae again 7");
        fill_to(8); settle(); chk_flags("R9 default ae again 8");
        load(3); ae_o = 3;
        settle(); chk_flags("R9 first strobe after reset sets ae");
        drain_to(4); settle(); chk_flags("R9 ae=3 at 4");
        drain_to(3); settle(); chk_flags("R9 ae=3 at 3");
        drain_to(0); settle();

        // R1/R2 streaming with unrelated clocks
        wdone = 0;
        fork
            begin
                for (int i = 0; i < 700; i++) begin
                    wr(seq, (i % 5) != 0, 1);
                    seq = seq + 9'd11;
                end
                wdone = 1;
            end
            begin
                while (!wdone || sb.size() > 0) rd();
            end
        join
        settle(); chk_flags("after streaming");

        finish_run();
    end
endmodule